// File: doc/BRIEF.md
# Slice Deferral Buffer

This block holds the instructions that a load-latency-tolerant in-order core pulls out of its pipeline because they wait on a load miss. Each instruction is written in program order together with the operand values it already has. It also carries a vector of the outstanding-miss tags it is still waiting on. Writing it into the buffer frees its pipeline slot, so younger instructions keep issuing.

When a miss returns, its tag is queued. In the next idle cycle the buffer starts a pass. The pass clears that tag's bit in every held entry at once. It then sends out, one per cycle and oldest first, every entry whose vector is now all zero. The reinjected instructions go back to the register-read stage with their captured operands. Entries that still wait on other misses stay in place, in their relative order, for a later pass.

Only one pass runs at a time. A deferral write wins over a reinjection in the same cycle. A flush from checkpoint rollback empties the buffer and drops all queued returns in a single cycle.

Top module: `slice_defer_buf`

## Requirements
- R1: A deferral is accepted in a cycle with def_valid high, def_ready high and flush low. The instruction word and both operand values are stored, and a later reinjection of that entry presents exactly those three values on rij_instr, rij_opa and rij_opb.
- R2: def_ready is low exactly while all DEPTH entries are held. A deferral offered while def_ready is low is not stored and never reinjected.
- R3: A miss return (ret_valid with tag ret_tag) is queued. When no pass is active, the next cycle starts a pass that clears bit ret_tag of the wait vector (bit i stands for tag i) in every held entry.
- R4: During a pass, each cycle with no accepted deferral reinjects the oldest held entry whose wait vector is all zero, and removes it. A return seen in an idle cycle produces its first reinjection two cycles later.
- R5: An entry whose wait vector is still nonzero is skipped by a pass. It keeps its order relative to the other held entries and is reinjected by a later pass once its vector clears.
- R6: A pass ends in the first cycle in which no held entry is eligible, with rij_valid low in that cycle. The next queued return can start a pass in the following cycle.
- R7: A return that arrives while a pass is active is kept and serviced by a pass after the current one ends.
- R8: An accepted deferral suppresses reinjection in the same cycle, and the waiting eligible entry is reinjected in a later cycle. A refused deferral (def_ready low) does not suppress reinjection.
- R9: While flush is high, rij_valid is low and any deferral is ignored. Afterwards the buffer holds no entries and no queued returns, and def_ready is high.
- R10: After reset, def_ready is high and rij_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Rollback flush: empties entries and return queue |
| def_valid | input | 1 | Deferral request |
| def_instr | input | IW | Instruction word to defer |
| def_opa | input | DW | Captured first operand value |
| def_opb | input | DW | Captured second operand value |
| def_wait | input | TAGS | Miss tags the instruction waits on, bit i = tag i |
| def_ready | output | 1 | Buffer can accept a deferral |
| ret_valid | input | 1 | A miss has returned |
| ret_tag | input | TW | Tag of the returning miss |
| rij_valid | output | 1 | An instruction is reinjected this cycle |
| rij_instr | output | IW | Reinjected instruction word |
| rij_opa | output | DW | Reinjected first operand value |
| rij_opb | output | DW | Reinjected second operand value |

## Verification
The bound checker watches the occupancy bookkeeping on every cycle. It checks that an accepted write adds exactly one entry, that a reinjection removes exactly one, that a write and a reinjection never happen together, and that a flush leaves the buffer empty and ready. Which entry comes out and in what order can only be shown by the bench's scenarios. These cover skipped entries surviving into later passes, returns queued during a pass, refused writes that never reappear, and a flush that discards a pending return. Operand capture is shown the same way, by comparing the reinjected values against what was written.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PASS = 1'b1
    } pass_st_e;

endpackage

// File: rtl/sdb_pick.sv
// Lowest-index request finder: the oldest entry or the lowest tag.
module sdb_pick #(
    parameter int N   = 8,
    parameter int IXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic           found,
    output logic [IXW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IXW'(i);
            end
        end
    end

endmodule

// File: rtl/sdb_retq.sv
// Queue of returned miss tags, kept as a mask; the lowest tag is served first.
module sdb_retq #(
    parameter int TAGS = 8,
    parameter int TW   = $clog2(TAGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          ret_valid,
    input  logic [TW-1:0] ret_tag,
    input  logic          take,
    output logic          any,
    output logic [TW-1:0] sel_tag
);

    typedef struct packed {
        logic [TAGS-1:0] pend;
    } rq_t;

    rq_t rq_d, rq_q;

    sdb_pick #(.N(TAGS), .IXW(TW)) u_pick (
        .req   (rq_q.pend),
        .found (any),
        .idx   (sel_tag)
    );

    always_comb begin
        rq_d = rq_q;
        for (int t = 0; t < TAGS; t++) begin
            if (take && (TW'(t) == sel_tag)) begin
                rq_d.pend[t] = 1'b0;
            end
            if (ret_valid && (TW'(t) == ret_tag)) begin
                rq_d.pend[t] = 1'b1;
            end
        end
        if (flush) begin
            rq_d.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else begin
            rq_q <= rq_d;
        end
    end

endmodule

// File: rtl/sdb_store.sv
// Compacting entry array: index 0 is always the oldest held entry.
module sdb_store #(
    parameter int DEPTH = 8,
    parameter int TAGS  = 8,
    parameter int IW    = 16,
    parameter int DW    = 16,
    parameter int TW    = $clog2(TAGS),
    parameter int IXW   = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_instr,
    input  logic [DW-1:0]    wr_opa,
    input  logic [DW-1:0]    wr_opb,
    input  logic [TAGS-1:0]  wr_wait,
    input  logic             clr_en,
    input  logic [TW-1:0]    clr_tag,
    input  logic             rd_en,
    input  logic [IXW-1:0]   rd_idx,
    output logic [CW-1:0]    cnt,
    output logic [DEPTH-1:0] elig,
    output logic [IW-1:0]    rd_instr,
    output logic [DW-1:0]    rd_opa,
    output logic [DW-1:0]    rd_opb
);

    typedef struct packed {
        logic [IW-1:0]   instr;
        logic [DW-1:0]   opa;
        logic [DW-1:0]   opb;
        logic [TAGS-1:0] wv;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] e;
        logic [CW-1:0]    cnt;
    } st_t;

    st_t st_d, st_q;
    ent_t wr_ent;

    assign wr_ent = '{instr: wr_instr, opa: wr_opa, opb: wr_opb, wv: wr_wait};
    assign cnt    = st_q.cnt;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_elig
            assign elig[g] = (CW'(g) < st_q.cnt) && (st_q.e[g].wv == '0);
        end
    endgenerate

    always_comb begin
        rd_instr = '0;
        rd_opa   = '0;
        rd_opb   = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (IXW'(j) == rd_idx) begin
                rd_instr = st_q.e[j].instr;
                rd_opa   = st_q.e[j].opa;
                rd_opb   = st_q.e[j].opb;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        // removal closes the gap, so the survivors keep their order
        if (rd_en) begin
            for (int j = 0; j < DEPTH - 1; j++) begin
                if (IXW'(j) >= rd_idx) begin
                    st_d.e[j] = st_q.e[j + 1];
                end
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (CW'(j) == st_q.cnt) begin
                    st_d.e[j] = wr_ent;
                end
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (clr_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                for (int t = 0; t < TAGS; t++) begin
                    if (TW'(t) == clr_tag) begin
                        st_d.e[j].wv[t] = 1'b0;
                    end
                end
            end
        end
        if (flush) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/slice_defer_buf.sv
module slice_defer_buf
    import sdb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAGS  = 8,
    parameter int IW    = 16,
    parameter int DW    = 16,
    parameter int TW    = $clog2(TAGS),
    parameter int IXW   = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            def_valid,
    input  logic [IW-1:0]   def_instr,
    input  logic [DW-1:0]   def_opa,
    input  logic [DW-1:0]   def_opb,
    input  logic [TAGS-1:0] def_wait,
    output logic            def_ready,
    input  logic            ret_valid,
    input  logic [TW-1:0]   ret_tag,
    output logic            rij_valid,
    output logic [IW-1:0]   rij_instr,
    output logic [DW-1:0]   rij_opa,
    output logic [DW-1:0]   rij_opb
);

    typedef struct packed {
        pass_st_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CW-1:0]    cnt;
    logic [DEPTH-1:0] elig;
    logic             found;
    logic [IXW-1:0]   pidx;
    logic             q_any;
    logic [TW-1:0]    q_tag;
    logic             take;
    logic             rd_en;
    logic             wr_acc;

    assign def_ready = (cnt != CW'(DEPTH));
    assign wr_acc    = def_valid && def_ready && !flush;

    sdb_retq #(.TAGS(TAGS), .TW(TW)) u_retq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .take      (take),
        .any       (q_any),
        .sel_tag   (q_tag)
    );

    sdb_pick #(.N(DEPTH), .IXW(IXW)) u_oldest (
        .req   (elig),
        .found (found),
        .idx   (pidx)
    );

    sdb_store #(
        .DEPTH (DEPTH),
        .TAGS  (TAGS),
        .IW    (IW),
        .DW    (DW),
        .TW    (TW),
        .IXW   (IXW),
        .CW    (CW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_acc),
        .wr_instr (def_instr),
        .wr_opa   (def_opa),
        .wr_opb   (def_opb),
        .wr_wait  (def_wait),
        .clr_en   (take),
        .clr_tag  (q_tag),
        .rd_en    (rd_en),
        .rd_idx   (pidx),
        .cnt      (cnt),
        .elig     (elig),
        .rd_instr (rij_instr),
        .rd_opa   (rij_opa),
        .rd_opb   (rij_opb)
    );

    always_comb begin
        ctl_d     = ctl_q;
        take      = 1'b0;
        rd_en     = 1'b0;
        rij_valid = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (q_any) begin
                    take     = 1'b1;
                    ctl_d.st = ST_PASS;
                end
            end
            ST_PASS: begin
                if (found) begin
                    if (!wr_acc) begin
                        rd_en     = 1'b1;
                        rij_valid = 1'b1;
                    end
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        if (flush) begin
            take      = 1'b0;
            rd_en     = 1'b0;
            rij_valid = 1'b0;
            ctl_d.st  = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/sdb_chk.sv
module sdb_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          def_valid,
    input logic          def_ready,
    input logic          rij_valid,
    input logic [CW-1:0] cnt
);

    // R1
    wr_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (def_valid && def_ready && !flush) |=> (cnt == $past(cnt) + 1'b1));

    // R4
    rd_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rij_valid && !flush) |=> (cnt == $past(cnt) - 1'b1));

    // R8
    wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (def_valid && def_ready && !flush) |-> !rij_valid);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((cnt == '0) && def_ready && !rij_valid));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R2
    full_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(def_ready) |-> $past(def_valid && !flush));

endmodule

bind slice_defer_buf sdb_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .def_valid (def_valid),
    .def_ready (def_ready),
    .rij_valid (rij_valid),
    .cnt       (cnt)
);

// File: tb/slice_defer_buf_test.sv
module slice_defer_buf_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        def_valid = 1'b0;
    logic [15:0] def_instr = '0;
    logic [15:0] def_opa = '0;
    logic [15:0] def_opb = '0;
    logic [7:0]  def_wait = '0;
    logic        def_ready;
    logic        ret_valid = 1'b0;
    logic [2:0]  ret_tag = '0;
    logic        rij_valid;
    logic [15:0] rij_instr;
    logic [15:0] rij_opa;
    logic [15:0] rij_opb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int got [16];
    int ng;

    always #5 clk = ~clk;

    slice_defer_buf uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .def_valid (def_valid),
        .def_instr (def_instr),
        .def_opa   (def_opa),
        .def_opb   (def_opb),
        .def_wait  (def_wait),
        .def_ready (def_ready),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .rij_valid (rij_valid),
        .rij_instr (rij_instr),
        .rij_opa   (rij_opa),
        .rij_opb   (rij_opb)
    );

    typedef struct packed {
        logic       dv;
        logic [7:0] ins;
        logic [7:0] wv;
        logic       rv;
        logic [2:0] tag;
        logic       erv;
        logic [7:0] eins;
    } row_t;

    localparam int NROWS = 18;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 8'h01, 8'h01, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b1, 8'h02, 8'h02, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b1, 8'h03, 8'h03, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b1, 8'h04, 8'h01, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'h01},
        '{1'b0, 8'h00, 8'h00, 1'b1, 3'd1, 1'b1, 8'h04},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b1, 8'h05, 8'h04, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'h02},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'h03},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b1, 3'd2, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 8'h05},
        '{1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        def_valid = 1'b0;
        def_instr = '0;
        def_opa   = '0;
        def_opb   = '0;
        def_wait  = '0;
        ret_valid = 1'b0;
        ret_tag   = '0;
        flush     = 1'b0;
    endtask

    task automatic set_def(input logic [7:0] ins, input logic [7:0] wv);
        def_valid = 1'b1;
        def_instr = {8'h00, ins};
        def_opa   = {8'hA5, ins};
        def_opb   = {ins, 8'h3C};
        def_wait  = wv;
    endtask

    // count reinjections over n cycles with quiet inputs
    task automatic collect(input int n);
        ng = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            idle_in();
            #1;
            if (rij_valid && ng < 16) begin
                got[ng] = int'(rij_instr);
                ng++;
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_seq [8];
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        @(negedge clk);
        #1;
        chk(def_ready == 1'b1, "R10 ready after reset", int'(def_ready), 1);
        chk(rij_valid == 1'b0, "R10 no reinjection after reset", int'(rij_valid), 0);

        // table: order, skipping, queued return, write priority, multi-pass
        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            idle_in();
            if (TBL[r].dv) set_def(TBL[r].ins, TBL[r].wv);
            ret_valid = TBL[r].rv;
            ret_tag   = TBL[r].tag;
            #1;
            chk(rij_valid == TBL[r].erv, "R4 R5 R6 R7 R8 rij_valid per cycle",
                int'(rij_valid), int'(TBL[r].erv));
            if (TBL[r].erv) begin
                chk(rij_instr == {8'h00, TBL[r].eins}, "R4 R5 reinjected instruction",
                    int'(rij_instr), int'(TBL[r].eins));
                chk(rij_opa == {8'hA5, TBL[r].eins}, "R1 operand a",
                    int'(rij_opa), int'({8'hA5, TBL[r].eins}));
                chk(rij_opb == {TBL[r].eins, 8'h3C}, "R1 operand b",
                    int'(rij_opb), int'({TBL[r].eins, 8'h3C}));
            end
        end

        // fill to capacity: odd entries wait on tag 4, even on tag 3
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            idle_in();
            #1;
            chk(def_ready == 1'b1, "R2 ready while not full", int'(def_ready), 1);
            set_def(8'h10 + 8'(i), (i % 2 == 1) ? 8'h10 : 8'h08);
        end
        @(negedge clk);
        idle_in();
        set_def(8'h99, 8'h10);
        ret_valid = 1'b1;
        ret_tag   = 3'd4;
        #1;
        chk(def_ready == 1'b0, "R2 ready low when full", int'(def_ready), 0);
        @(negedge clk);
        idle_in();
        ret_valid = 1'b1;
        ret_tag   = 3'd3;
        #1;
        chk(rij_valid == 1'b0, "R3 pass start cycle is quiet", int'(rij_valid), 0);
        @(negedge clk);
        idle_in();
        set_def(8'h9A, 8'h10);
        #1;
        chk(rij_valid == 1'b1, "R8 refused write does not block", int'(rij_valid), 1);
        chk(rij_instr == 16'h0011, "R8 first of tag-4 pass", int'(rij_instr), 16'h11);
        collect(14);
        exp_seq = '{8'h13, 8'h15, 8'h17, 8'h10, 8'h12, 8'h14, 8'h16, 0};
        chk(ng == 7, "R2 R7 count after full test", ng, 7);
        for (int i = 0; i < 7; i++) begin
            chk(got[i] == exp_seq[i], "R5 R7 order across passes", got[i], exp_seq[i]);
        end
        @(negedge clk);
        #1;
        chk(def_ready == 1'b1, "R2 ready after drain", int'(def_ready), 1);

        // flush drops entries and the queued return
        @(negedge clk);
        idle_in();
        set_def(8'h21, 8'h80);
        @(negedge clk);
        idle_in();
        ret_valid = 1'b1;
        ret_tag   = 3'd7;
        @(negedge clk);
        idle_in();
        flush = 1'b1;
        set_def(8'h22, 8'h80);
        #1;
        chk(rij_valid == 1'b0, "R9 quiet during flush", int'(rij_valid), 0);
        @(negedge clk);
        idle_in();
        #1;
        chk(def_ready == 1'b1, "R9 ready after flush", int'(def_ready), 1);
        set_def(8'h23, 8'h80);
        collect(5);
        chk(ng == 0, "R9 queued return discarded", ng, 0);
        @(negedge clk);
        idle_in();
        ret_valid = 1'b1;
        ret_tag   = 3'd7;
        collect(6);
        chk(ng == 1, "R9 only post-flush entry remains", ng, 1);
        chk(got[0] == 16'h23, "R9 post-flush entry", got[0], 16'h23);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule